// File: doc/BRIEF.md
# Shared Interrupt Target Routing Registers

This block stores, for every shared interrupt from number 32 up to a configured limit, the single processor that the interrupt is delivered to. Software reaches the routing through a window of 32-bit target words. Each word carries four interrupts, one byte per interrupt. A written byte may have several bits set. The block keeps only the lowest set bit and reduces the byte to one processor index. Reads return that index as a one-hot byte.

The stored routing is also presented as one bitmap per processor. Pending-interrupt logic further down the chain can then mask shared interrupts by destination without decoding target indices. The first eight target words belong to the private interrupts 0 to 31. They are not stored. A read of them returns the requesting processor's own bit in all four bytes, and writes to them are dropped.

The same register port also holds a one-bit global distributor enable and a read-only type word. The type word reports the number of online processors and the number of interrupt lines. After each write that can change routing or the enable, a one-cycle strobe tells the surrounding logic to re-evaluate its state.

Top module: `irq_route_regs`

## Requirements
- R1: After reset every shared interrupt is routed to processor 0, the global enable is 0, `state_changed` is 0 and `rd_valid` is 0.
- R2: A read request (`req_valid`=1, `req_write`=0) returns its data on `rd_data` with `rd_valid`=1 exactly one cycle later. A shared target byte reads as `1 << target`.
- R3: A written target byte routes its interrupt to the processor given by the index of its lowest set bit. A byte of zero routes to processor 0.
- R4: Target words start at byte address 0x800. Word k (address 0x800 + 4k) covers interrupts 4k..4k+3, and interrupt 4k+i uses bits 8i+7..8i.
- R5: `route_map` bit c*NUM_SPI + (n-32) is 1 exactly when shared interrupt n is routed to processor c. At most one processor bit is set per interrupt.
- R6: Target words 0 to 7 (private interrupts) read as `1 << req_cpu` in each of the four bytes. Writes to them change no routing and raise no strobe.
- R7: The control word at address 0x000 stores only write-data bit 0 as `dist_enable`. It reads back as that bit, with all other bits zero.
- R8: The type word at address 0x004 reads as ((online_cpus - 1) << 5) | (NUM_IRQS/32 - 1). Writes to it have no effect.
- R9: `state_changed` is 1 for exactly the cycle after a write to the control word or to an implemented shared target word. It is 0 after any other access and after idle cycles.
- R10: Target words at or beyond NUM_IRQS/4 read as zero. Writes to them change no routing and raise no strobe.
- R11: Any other address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 3 | Index of the requesting processor |
| online_cpus | input | 4 | Number of online processors, 1 to 8 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| dist_enable | output | 1 | Global distributor enable |
| state_changed | output | 1 | One-cycle re-evaluate strobe |
| route_map | output | NUM_CPUS*(NUM_IRQS-32) | Per-processor routing bitmaps |

## Verification
Read data, the routing bitmaps, the enable and the strobe all come from registers, so each result is due at the clock edge that samples the request. The bench drives every request at a falling edge and removes it at the next falling edge. It samples `rd_data`, `rd_valid`, `state_changed`, `dist_enable` and `route_map` at that same falling edge, which is half a cycle after they update.

At the following falling edge the bench checks again that the strobe has dropped. The check of ignored writes reads the target word back through the register port and compares the complete routing bitmap against a model kept in the bench.

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int NUM_IRQS = 96,
  parameter int NUM_CPUS = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  input  logic                                req_write,
  input  logic [11:0]                         req_addr,
  input  logic [31:0]                         req_wdata,
  input  logic [2:0]                          req_cpu,
  input  logic [3:0]                          online_cpus,
  output logic                                rd_valid,
  output logic [31:0]                         rd_data,
  output logic                                dist_enable,
  output logic                                state_changed,
  output logic [NUM_CPUS*(NUM_IRQS-32)-1:0]   route_map
);

  localparam int NUM_SPI   = NUM_IRQS - 32;
  localparam int PRIV_WRDS = 8;
  localparam int TGT_WRDS  = NUM_IRQS / 4;

  logic [2:0] tgt [NUM_SPI];

  logic is_ctl, is_typ, is_tgt, is_priv, is_shared;
  logic do_wr, do_rd;
  int   widx;
  logic [31:0] rd_next;

  assign widx      = int'(req_addr[9:2]);
  assign is_ctl    = (req_addr[11:2] == 10'd0);
  assign is_typ    = (req_addr[11:2] == 10'd1);
  assign is_tgt    = (req_addr[11:10] == 2'b10);
  assign is_priv   = is_tgt && (widx < PRIV_WRDS);
  assign is_shared = is_tgt && (widx >= PRIV_WRDS) && (widx < TGT_WRDS);
  assign do_wr     = req_valid && req_write;
  assign do_rd     = req_valid && !req_write;

  function automatic logic [2:0] lowest_set(input logic [7:0] b);
    logic [2:0] idx;
    idx = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (b[i]) idx = 3'(i);
    return idx;
  endfunction

  for (genvar j = 0; j < NUM_SPI; j++) begin : g_spi
    localparam int WORD = PRIV_WRDS + j / 4;
    localparam int LANE = j % 4;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tgt[j] <= 3'd0;
      else if (do_wr && is_shared && widx == WORD)
        tgt[j] <= lowest_set(req_wdata[8*LANE +: 8]);
    end
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      assign route_map[c*NUM_SPI + j] = (tgt[j] == 3'(c));
    end
  end

  always_comb begin
    rd_next = 32'd0;
    if (is_ctl)
      rd_next = {31'd0, dist_enable};
    else if (is_typ)
      rd_next = {24'd0, 3'(online_cpus - 4'd1), 5'(NUM_IRQS / 32 - 1)};
    else if (is_priv)
      rd_next = {4{8'd1 << req_cpu}};
    else if (is_shared) begin
      for (int j = 0; j < NUM_SPI; j++)
        if (PRIV_WRDS + j / 4 == widx)
          rd_next[8*(j%4) +: 8] = 8'd1 << tgt[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid      <= 1'b0;
      rd_data       <= 32'd0;
      dist_enable   <= 1'b0;
      state_changed <= 1'b0;
    end else begin
      rd_valid      <= do_rd;
      if (do_rd) rd_data <= rd_next;
      if (do_wr && is_ctl) dist_enable <= req_wdata[0];
      state_changed <= do_wr && (is_ctl || is_shared);
    end
  end

  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_rd |=> rd_valid);
  assert_no_spurious_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !do_rd |=> !rd_valid);
  assert_priv_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && is_priv) |=> rd_data == {4{8'd1 << $past(req_cpu)}});
  assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_wr && is_ctl) |=> $stable(dist_enable));
  assert_strobe_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !do_wr |=> !state_changed);
  assert_type_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && is_typ) |=> !state_changed);

  for (genvar j = 0; j < NUM_SPI; j++) begin : g_chk
    logic [NUM_CPUS-1:0] col;
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_col
      assign col[c] = route_map[c*NUM_SPI + j];
    end
    assert_single_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(col) <= 1);
  end

endmodule

// File: tb/tb_irq_route_regs.sv
module tb_irq_route_regs;
  localparam int NUM_IRQS = 96;
  localparam int NUM_CPUS = 8;
  localparam int NUM_SPI  = NUM_IRQS - 32;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic [2:0] req_cpu;
  logic [3:0] online_cpus;
  logic rd_valid, dist_enable, state_changed;
  logic [31:0] rd_data;
  logic [NUM_CPUS*NUM_SPI-1:0] route_map;

  int vectors = 0;
  int miscompares = 0;
  int exp_tgt [NUM_SPI];
  logic last_strobe;
  logic [31:0] got;

  always #4 clk = ~clk;

  irq_route_regs #(.NUM_IRQS(NUM_IRQS), .NUM_CPUS(NUM_CPUS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .online_cpus(online_cpus), .rd_valid(rd_valid), .rd_data(rd_data),
    .dist_enable(dist_enable), .state_changed(state_changed),
    .route_map(route_map));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    last_strobe = state_changed;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [2:0] cpu);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_cpu = cpu;
    @(negedge clk);
    got = rd_data;
    check("R2 rd_valid", {31'd0, rd_valid}, 32'd1);
    req_valid = 1'b0;
  endtask

  task automatic check_map(input string req);
    logic [NUM_CPUS*NUM_SPI-1:0] exp;
    for (int c = 0; c < NUM_CPUS; c++)
      for (int j = 0; j < NUM_SPI; j++)
        exp[c*NUM_SPI + j] = (exp_tgt[j] == c);
    vectors++;
    if (route_map !== exp) begin
      miscompares++;
      $display("FAIL %s: route_map %h expected %h", req, route_map, exp);
    end
  endtask

  task automatic t_reset;
    check("R1 enable", {31'd0, dist_enable}, 32'd0);
    check("R1 strobe", {31'd0, state_changed}, 32'd0);
    check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    check_map("R1 route_map");
    rd(12'h820, 3'd0); check("R1 word 8", got, 32'h01010101);
    rd(12'h85C, 3'd0); check("R1 word 23", got, 32'h01010101);
  endtask

  task automatic t_lowest_bit;
    wr(12'h820, 32'h800C0006);
    check("R9 strobe on target write", {31'd0, last_strobe}, 32'd1);
    @(negedge clk);
    check("R9 strobe one cycle", {31'd0, state_changed}, 32'd0);
    exp_tgt[0] = 1; exp_tgt[1] = 0; exp_tgt[2] = 2; exp_tgt[3] = 7;
    rd(12'h820, 3'd0); check("R3 R4 word 8 readback", got, 32'h80040102);
    check_map("R5 after word 8");
  endtask

  task automatic t_lanes;
    wr(12'h85C, 32'hFFFFFFFF);
    rd(12'h85C, 3'd0); check("R3 all-ones bytes", got, 32'h01010101);
    wr(12'h85C, 32'h40201008);
    for (int i = 0; i < 4; i++) exp_tgt[60 + i] = 3 + i;
    rd(12'h85C, 3'd0); check("R4 lanes word 23", got, 32'h40201008);
    wr(12'h824, 32'h00000000);
    rd(12'h824, 3'd0); check("R3 zero byte", got, 32'h01010101);
    check_map("R5 after word 23");
    wr(12'h85C, 32'h00000000);
    for (int i = 0; i < 4; i++) exp_tgt[60 + i] = 0;
    check_map("R5 rerouted to cpu0");
  endtask

  task automatic t_private;
    rd(12'h800, 3'd5); check("R6 private cpu5", got, 32'h20202020);
    wr(12'h80C, 32'h00000000);
    check("R6 no strobe", {31'd0, last_strobe}, 32'd0);
    rd(12'h80C, 3'd2); check("R6 private cpu2 after write", got, 32'h04040404);
    check_map("R6 map unchanged");
  endtask

  task automatic t_control;
    wr(12'h000, 32'hFFFFFFFE);
    check("R9 strobe on control", {31'd0, last_strobe}, 32'd1);
    check("R7 enable bit0 only", {31'd0, dist_enable}, 32'd0);
    rd(12'h000, 3'd0); check("R7 read 0", got, 32'd0);
    wr(12'h000, 32'h00000003);
    check("R7 enable set", {31'd0, dist_enable}, 32'd1);
    rd(12'h000, 3'd0); check("R7 read 1", got, 32'd1);
  endtask

  task automatic t_type;
    online_cpus = 4'd4;
    rd(12'h004, 3'd0); check("R8 type 4 cpus", got, 32'h00000062);
    wr(12'h004, 32'hFFFFFFFF);
    check("R8 no strobe", {31'd0, last_strobe}, 32'd0);
    rd(12'h004, 3'd0); check("R8 type after write", got, 32'h00000062);
    online_cpus = 4'd8;
    rd(12'h004, 3'd0); check("R8 type 8 cpus", got, 32'h000000E2);
    check("R8 enable kept", {31'd0, dist_enable}, 32'd1);
  endtask

  task automatic t_beyond;
    wr(12'h860, 32'h80808080);
    check("R10 no strobe", {31'd0, last_strobe}, 32'd0);
    rd(12'h860, 3'd0); check("R10 beyond reads 0", got, 32'd0);
    check_map("R10 map unchanged");
    rd(12'h100, 3'd0); check("R11 unmapped reads 0", got, 32'd0);
    @(negedge clk);
    check("R2 idle no rd_valid", {31'd0, rd_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_cpu = '0; online_cpus = 4'd8; last_strobe = 1'b0;
    for (int j = 0; j < NUM_SPI; j++) exp_tgt[j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_lowest_bit;
    t_lanes;
    t_private;
    t_control;
    t_type;
    t_beyond;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule